// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block sits between a processor's load/store path and memory. It turns each 32-bit logical address into a physical address by means of a descriptor table held in ordinary memory. The upper 13 bits of the logical address are an index into that table. The remaining 19 bits are an offset into the segment that the indexed descriptor describes. The table's start address and a protected-mode enable sit in one configuration register, which is loaded through a dedicated write strobe.

When protected mode is enabled, an accepted request starts a walk. The block reads the 8-byte descriptor as two 32-bit words over its own memory read port, low word first. It then checks the descriptor's presence, the caller's privilege and the segment limit, and returns either the base plus the offset or a fault code. Index 0 is a reserved null slot that faults without any memory access. When protected mode is disabled, the logical address is returned unchanged one cycle after acceptance. Only one request is in flight at a time.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the configuration register holds base 0 with protected mode disabled, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A configuration write applies to requests accepted after its clock edge. A request accepted in the same cycle as a write uses the base and mode that were in force before the write.
- R3: With protected mode disabled, the response arrives in the cycle after acceptance with `rsp_paddr` equal to the request address and fault 0, and no memory read is issued.
- R4: A walk reads the word at table base + index*8 first, and then the word at that address + 4. The read address stays stable while a read waits for `mem_req_ready`.
- R5: In protected mode an index of 0 returns fault 1 (null) in the cycle after acceptance, with no memory read.
- R6: The descriptor layout is: low word = segment base; high word bits [19:0] = length in bytes, bit 20 = kernel-only, bit 21 = present. A descriptor whose present bit is clear gives fault 2.
- R7: A kernel-only segment accessed with `req_user` = 1 gives fault 3.
- R8: An offset (address bits [18:0]) that is greater than or equal to the length gives fault 4.
- R9: A granted access returns the segment base plus the offset with fault 0. For example, base 200000 with offset 16384 gives 216384.
- R10: When several checks fail at once, the reported fault follows the order not-present, then privilege, then limit.
- R11: From acceptance until its response, `req_ready` stays low. Every accepted request gets exactly one single-cycle response, and the fault code never exceeds 4.
- R12: Every faulting response carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_base | input | 32 | New table start address |
| cfg_pmode | input | 1 | New protected-mode enable |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Logical address |
| req_user | input | 1 | 1 = user-mode caller |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 null, 2 not present, 3 privilege, 4 limit |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |

## Verification
Two of this block's functions can fall in the same cycle: a configuration write and the acceptance of a translation request. The bench provokes this by driving `cfg_we` together with `req_valid` while the block is idle. In one case the write moves the table base, and the bench judges the outcome by the descriptor address that then appears on the memory port, which must still use the old base. In the other case the write turns protected mode off, and that request must still be walked, while the request after it must come back untranslated in one cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_LIMIT  = 3'd4
  } seg_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_WT_LO,
    ST_RD_HI,
    ST_WT_HI
  } walk_st_e;
endpackage

// File: rtl/seg_cfg_reg.sv
module seg_cfg_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] base_in,
  input  logic          pmode_in,
  output logic [AW-1:0] base_q,
  output logic          pmode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      pmode_q <= 1'b0;
    end else if (we) begin
      base_q  <= base_in;
      pmode_q <= pmode_in;
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 13,
  parameter int LEN_W = 20,
  localparam int OFF_W = AW - IDX_W
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  offset,
  input  logic              user,
  output seg_fault_e        fault,
  output logic [AW-1:0]     paddr
);
  localparam int KERN_BIT = LEN_W;
  localparam int PRES_BIT = LEN_W + 1;

  function automatic seg_fault_e judge(input logic [WORD_W-1:0] hi,
                                       input logic [OFF_W-1:0] off,
                                       input logic usr);
    logic [LEN_W:0] off_x, len_x;
    off_x = (LEN_W + 1)'(off);
    len_x = {1'b0, hi[LEN_W-1:0]};
    if (!hi[PRES_BIT])              return FLT_ABSENT;
    else if (hi[KERN_BIT] && usr)   return FLT_PRIV;
    else if (off_x >= len_x)        return FLT_LIMIT;
    else                            return FLT_NONE;
  endfunction

  function automatic logic [AW-1:0] relocate(input logic [WORD_W-1:0] seg_base,
                                             input logic [OFF_W-1:0] off);
    return AW'(seg_base) + AW'(off);
  endfunction

  logic unused_hi_bits;
  assign unused_hi_bits = ^hi_word[WORD_W-1:PRES_BIT+1];

  always_comb begin
    fault = judge(hi_word, offset, user);
    paddr = (fault == FLT_NONE) ? relocate(lo_word, offset) : '0;
  end
endmodule

// File: rtl/seg_walk_fsm.sv
module seg_walk_fsm
  import seg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 13,
  localparam int OFF_W = AW - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     tbl_base,
  input  logic              pmode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [WORD_W-1:0] lo_q,
  output logic [OFF_W-1:0]  off_q,
  output logic              user_q,
  input  seg_fault_e        chk_fault,
  input  logic [AW-1:0]     chk_paddr,
  output logic              acc_fire,
  output logic              walk_done,
  output logic              rsp_valid,
  output logic [AW-1:0]     rsp_paddr,
  output seg_fault_e        rsp_fault
);
  walk_st_e         st;
  logic [AW-1:0]    ptr;
  logic [IDX_W-1:0] idx;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                              input logic [IDX_W-1:0] i);
    return base + (AW'(i) << 3);
  endfunction

  assign idx           = req_addr[AW-1 -: IDX_W];
  assign req_ready     = (st == ST_IDLE);
  assign acc_fire      = req_valid && req_ready;
  assign mem_req_valid = (st == ST_RD_LO) || (st == ST_RD_HI);
  assign mem_req_addr  = ptr;
  assign walk_done     = (st == ST_WT_HI) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      lo_q      <= '0;
      off_q     <= '0;
      user_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (acc_fire) begin
          if (!pmode) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= req_addr;
            rsp_fault <= FLT_NONE;
          end else if (idx == '0) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NULL;
          end else begin
            ptr    <= slot_addr(tbl_base, idx);
            off_q  <= req_addr[OFF_W-1:0];
            user_q <= req_user;
            st     <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_req_ready) st <= ST_WT_LO;
        ST_WT_LO: if (mem_rsp_valid) begin
          lo_q <= mem_rsp_data;
          ptr  <= ptr + AW'(4);
          st   <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_req_ready) st <= ST_WT_HI;
        ST_WT_HI: if (walk_done) begin
          rsp_valid <= 1'b1;
          rsp_paddr <= chk_paddr;
          rsp_fault <= chk_fault;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 13,
  parameter int LEN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_base,
  input  logic              cfg_pmode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [AW-1:0]     rsp_paddr,
  output logic [2:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int OFF_W = AW - IDX_W;

  logic [AW-1:0]     base_q;
  logic              pmode_q;
  logic [WORD_W-1:0] lo_q;
  logic [OFF_W-1:0]  off_q;
  logic              user_q;
  seg_fault_e        chk_fault, fault_q;
  logic [AW-1:0]     chk_paddr;
  logic              acc_fire, walk_done;

  seg_cfg_reg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .base_in(cfg_base),
    .pmode_in(cfg_pmode), .base_q(base_q), .pmode_q(pmode_q)
  );

  seg_walk_fsm #(.AW(AW), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .tbl_base(base_q), .pmode(pmode_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_user(req_user), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lo_q(lo_q), .off_q(off_q), .user_q(user_q),
    .chk_fault(chk_fault), .chk_paddr(chk_paddr),
    .acc_fire(acc_fire), .walk_done(walk_done),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(fault_q)
  );

  seg_check #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk_logic (
    .lo_word(lo_q), .hi_word(mem_rsp_data), .offset(off_q),
    .user(user_q), .fault(chk_fault), .paddr(chk_paddr)
  );

  assign rsp_fault = fault_q;
endmodule

// File: rtl/seg_xlate_unit_checker.sv
module seg_xlate_unit_checker #(
  parameter int AW    = 32,
  parameter int IDX_W = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          pmode_q,
  input logic          acc_fire,
  input logic          walk_done,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_paddr,
  input logic [2:0]    rsp_fault,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr
);
  // R3: untranslated path answers next cycle with the same address
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pmode_q) |=>
      (rsp_valid && rsp_paddr == $past(req_addr) && rsp_fault == 3'd0));

  // R5: null slot faults next cycle without memory traffic
  assert_null_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pmode_q && req_addr[AW-1 -: IDX_W] == '0) |=>
      (rsp_valid && rsp_fault == 3'd1 && rsp_paddr == '0 && !mem_req_valid));

  // R4: a pending read holds its address
  assert_rd_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11: no memory read while the request side is open
  assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R11: a finished walk produces a response next cycle
  assert_walk_answers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> (rsp_valid && req_ready));

  // R11: fault code within its range
  assert_fault_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));

  // R12: faulting responses carry a zero address
  assert_fault_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
endmodule

bind seg_xlate_unit seg_xlate_unit_checker #(.AW(AW), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .pmode_q(pmode_q), .acc_fire(acc_fire),
  .walk_done(walk_done), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_pmode = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic [2:0]  rsp_fault;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  logic [31:0] cur_tb = '0;
  logic        cur_pm = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_pmode(cfg_pmode), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // descriptor contents computed per slot
  function automatic logic [31:0] d_lo(input int i);
    if (i == 9) return 32'd200000;
    return i * 32'h10000 + 32'h123;
  endfunction
  function automatic logic [19:0] d_len(input int i);
    if (i == 9) return 20'd32768;
    return 20'((i * 24593) % 32'h90000);
  endfunction
  function automatic logic d_kern(input int i);
    return (i != 9) && (i % 5 == 2);
  endfunction
  function automatic logic d_pres(input int i);
    return (i == 9) || (i % 7 != 3);
  endfunction
  function automatic logic [31:0] d_hi(input int i);
    return {10'b0, d_pres(i), d_kern(i), d_len(i)};
  endfunction
  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] tb);
    logic [31:0] rel;
    rel = a - tb;
    return rel[2] ? d_hi(int'(rel >> 3)) : d_lo(int'(rel >> 3));
  endfunction

  task automatic do_req(input logic [31:0] a, input logic u, input logic wr,
                        input logic [31:0] wb, input logic wp, input string note);
    int idx, nm, lat, stall, cnt, ncond;
    logic [18:0] off;
    logic [31:0] maddr [0:3];
    logic [31:0] ep, gp, pend_a, tb_used;
    logic [2:0]  ef, gf;
    logic got, pend, busy_bad, walked;
    string tag;
    idx = int'(a[31:19]); off = a[18:0];
    nm = 0; lat = 0; got = 0; pend = 0; busy_bad = 0; cnt = 0; stall = idx % 2;
    tb_used = cur_tb; pend_a = '0; gp = '0; gf = '0; ncond = 0;
    walked = cur_pm && idx != 0;
    if (!cur_pm) begin ep = a; ef = 3'd0; tag = "R3"; end
    else if (idx == 0) begin ep = 0; ef = 3'd1; tag = "R5"; end
    else begin
      ncond = int'(!d_pres(idx)) + int'(d_kern(idx) && u) + int'({1'b0, off} >= d_len(idx));
      if (!d_pres(idx)) begin ef = 3'd2; tag = "R6"; end
      else if (d_kern(idx) && u) begin ef = 3'd3; tag = "R7"; end
      else if ({1'b0, off} >= d_len(idx)) begin ef = 3'd4; tag = "R8"; end
      else begin ef = 3'd0; tag = "R9"; end
      ep = (ef == 3'd0) ? d_lo(idx) + 32'(off) : 32'd0;
      if (ncond > 1) tag = "R10";
    end
    @(negedge clk);
    chk({"R11 ready before ", note}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_user = u;
    cfg_we = wr; cfg_base = wb; cfg_pmode = wp;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    if (wr) begin cur_tb = wb; cur_pm = wp; end
    for (int n = 1; n <= 100 && !got; n++) begin
      if (n > 1) @(negedge clk);
      mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
      if (rsp_valid) begin got = 1; lat = n; gp = rsp_paddr; gf = rsp_fault; end
      else begin
        if (req_ready) busy_bad = 1;
        if (pend) begin
          if (cnt == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(pend_a, tb_used); pend = 0;
          end else cnt--;
        end else if (mem_req_valid) begin
          if (stall > 0) stall--;
          else begin
            mem_req_ready = 1'b1;
            if (nm < 4) maddr[nm] = mem_req_addr;
            nm++; pend = 1; pend_a = mem_req_addr;
            cnt = (idx + nm) % 3; stall = (idx + nm) % 2;
          end
        end
      end
    end
    chk({"R11 response seen ", note}, 32'(got), 32'd1);
    chk({tag, " fault ", note}, 32'(gf), 32'(ef));
    chk({(ef != 0) ? "R12" : tag, " paddr ", note}, gp, ep);
    if (walked) begin
      chk({"R4 read count ", note}, 32'(nm), 32'd2);
      chk({"R4 low word addr ", note}, maddr[0], tb_used + 32'(idx * 8));
      chk({"R4 high word addr ", note}, maddr[1], tb_used + 32'(idx * 8) + 32'd4);
      chk({"R11 busy while walking ", note}, 32'(busy_bad), 32'd0);
    end else begin
      chk({tag, " no memory read ", note}, 32'(nm), 32'd0);
      chk({tag, " one-cycle latency ", note}, 32'(lat), 32'd1);
    end
  endtask

  task automatic set_cfg(input logic [31:0] b, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = b; cfg_pmode = p;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_tb = b; cur_pm = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [18:0] offs [0:3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    // R1: protected mode off after reset, so requests pass through
    do_req(32'h1234_5678, 1'b0, 1'b0, '0, 1'b0, "after reset");
    for (int k = 0; k < 16; k++)
      do_req(32'h9E37_79B9 * k + 32'h55, k[0], 1'b0, '0, 1'b0, "bypass sweep");

    set_cfg(32'h0004_0000, 1'b1);
    // R5: null slot, both modes of caller
    do_req(32'h0000_1234, 1'b0, 1'b0, '0, 1'b0, "null kernel");
    do_req(32'h0007_FFFF, 1'b1, 1'b0, '0, 1'b0, "null user");
    // R9: worked example
    do_req((32'd9 << 19) | 32'd16384, 1'b1, 1'b0, '0, 1'b0, "example");

    // R6 R7 R8 R9 R10: sweep slots, offsets around the limit, both callers
    for (int i = 1; i < 48; i++) begin
      offs[0] = '0;
      offs[1] = 19'(d_len(i) - 20'd1);
      offs[2] = 19'(d_len(i));
      offs[3] = 19'h7FFFF;
      for (int o = 0; o < 4; o++)
        for (int uu = 0; uu < 2; uu++)
          do_req({13'(i), offs[o]}, uu[0], 1'b0, '0, 1'b0, "slot sweep");
    end
    // R4: highest slots
    do_req({13'h1FFF, 19'h00010}, 1'b0, 1'b0, '0, 1'b0, "top slot");
    do_req({13'h1000, 19'h00000}, 1'b1, 1'b0, '0, 1'b0, "mid slot");

    // R2: base write in the acceptance cycle; old base must be fetched
    do_req({13'd12, 19'd5}, 1'b0, 1'b1, 32'h0080_0000, 1'b1, "R2 same-cycle base");
    do_req({13'd12, 19'd5}, 1'b0, 1'b0, '0, 1'b0, "R2 new base");
    // R2: mode switched off in the acceptance cycle; still walked, next bypassed
    do_req({13'd20, 19'd7}, 1'b1, 1'b1, 32'h0080_0000, 1'b0, "R2 same-cycle mode");
    do_req({13'd20, 19'd7}, 1'b1, 1'b0, '0, 1'b0, "R2 mode now off");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule